// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a small processor with one accumulator. Every instruction goes through the same sequence of phases. The core first fetches the instruction word into an instruction register and decodes it. Next it reads the operand into a temporary register, and then it updates the accumulator. A store instead writes the accumulator back to memory. All memory traffic passes through a memory address register and a memory data register. The address register drives the address bus, the data register drives the write data bus, and an active-low read/write strobe marks writes.

The word-addressed memory sits inside the block as a synchronous RAM. While reset is held, a load port fills it with a program and its data. Releasing reset starts execution at address zero. A halt instruction stops the machine and raises a status output.

Top module: `acc_cpu`

## Requirements
- R1: A synchronous active-high reset clears the program counter, instruction, address, data, operand and accumulator registers to zero. It also sets the strobe high (read), lowers `halted` and restarts at the fetch phase.
- R2: An instruction is a 16-bit word with the opcode in bits [15:12] and an address in bits [11:0]. Opcode 1 (load) copies the memory word at the address into the accumulator.
- R3: Opcode 2 (add) adds the memory word at the address to the accumulator, modulo 2^16.
- R4: Opcode 5 (multiply) replaces the accumulator with the low 16 bits of the product of the accumulator and the memory word at the address.
- R5: Opcode 3 (store) drives the address on `bus_addr` and the accumulator on `bus_wdata`, and pulls `bus_rw_n` low for exactly one cycle. The memory word is updated and the accumulator keeps its value.
- R6: Opcode 4 (jump) makes the next fetch come from the address field. The word after the jump is not executed.
- R7: Each fetch increments the program counter by one. The only other change to it is a jump.
- R8: Opcode 0 (halt) raises `halted` and holds it until reset. It freezes the program counter at the halt address plus one and issues no further writes.
- R9: Opcodes 6 to 15 act as no-ops. Execution resumes with the next sequential word.
- R10: Instruction latency from the start of fetch is 7 cycles for load, add and multiply, 6 for store, and 4 for jump, no-op and the halt decode.
- R11: While reset is held, `load_en` writes `load_data` into the memory word at `load_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Program/data load write enable |
| load_addr | input | MEM_AW | Load word address |
| load_data | input | DATA_W | Load word value |
| bus_addr | output | DATA_W-4 | Memory address register |
| bus_wdata | output | DATA_W | Memory data register |
| bus_rw_n | output | 1 | Read (1) / write (0) strobe |
| pc_o | output | DATA_W-4 | Program counter |
| acc_o | output | DATA_W | Accumulator |
| halted | output | 1 | Halt reached |

## Verification
The hardest case to reach is a store followed by a load from the same address. It shows that memory really took the write, and the only way to see it is through the accumulator. Each vector program therefore computes a result and stores it. It then reloads the result from memory before halting, and the bench checks the reloaded accumulator, the single-cycle strobe and the total cycle count. Separate programs place a store right after a jump, which must be skipped, and undefined opcodes ahead of a load.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_HLT = 4'd0;
  localparam logic [OPC_W-1:0] OPC_LDA = 4'd1;
  localparam logic [OPC_W-1:0] OPC_ADD = 4'd2;
  localparam logic [OPC_W-1:0] OPC_STO = 4'd3;
  localparam logic [OPC_W-1:0] OPC_JMP = 4'd4;
  localparam logic [OPC_W-1:0] OPC_MPY = 4'd5;

  typedef enum logic [3:0] {
    ST_FADDR, ST_FMEM, ST_FIR, ST_DEC, ST_OMEM,
    ST_OLD, ST_EXEC, ST_STORE, ST_WRITE, ST_HALT
  } state_e;

  typedef enum logic [1:0] {ALU_PASS, ALU_ADD, ALU_MUL} alu_op_e;
endpackage

// File: rtl/acc_cpu_ram.sv
module acc_cpu_ram #(
  parameter int DATA_W = 16,
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [MEM_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    case (op)
      ALU_ADD: res = acc + opnd;
      ALU_MUL: res = acc * opnd;
      default: res = opnd;
    endcase
  end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output logic             ld_mar_pc,
  output logic             inc_pc,
  output logic             ld_ir,
  output logic             ld_mar_ir,
  output logic             pc_jump,
  output logic             ld_tmp,
  output logic             ld_acc,
  output logic             wr_req,
  output alu_op_e          alu_op,
  output logic             halted
);
  state_e state, nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FADDR;
    else     state <= nxt;
  end

  assign halted = (state == ST_HALT);

  always_comb begin
    case (opcode)
      OPC_ADD: alu_op = ALU_ADD;
      OPC_MPY: alu_op = ALU_MUL;
      default: alu_op = ALU_PASS;
    endcase
  end

  always_comb begin
    ld_mar_pc = 1'b0;
    inc_pc    = 1'b0;
    ld_ir     = 1'b0;
    ld_mar_ir = 1'b0;
    pc_jump   = 1'b0;
    ld_tmp    = 1'b0;
    ld_acc    = 1'b0;
    wr_req    = 1'b0;
    nxt       = state;
    case (state)
      ST_FADDR: begin ld_mar_pc = 1'b1; inc_pc = 1'b1; nxt = ST_FMEM; end
      ST_FMEM:  nxt = ST_FIR;
      ST_FIR:   begin ld_ir = 1'b1; nxt = ST_DEC; end
      ST_DEC: begin
        case (opcode)
          OPC_LDA, OPC_ADD, OPC_MPY: begin ld_mar_ir = 1'b1; nxt = ST_OMEM; end
          OPC_STO: begin ld_mar_ir = 1'b1; nxt = ST_STORE; end
          OPC_JMP: begin pc_jump = 1'b1; nxt = ST_FADDR; end
          OPC_HLT: nxt = ST_HALT;
          default: nxt = ST_FADDR;
        endcase
      end
      ST_OMEM:  nxt = ST_OLD;
      ST_OLD:   begin ld_tmp = 1'b1; nxt = ST_EXEC; end
      ST_EXEC:  begin ld_acc = 1'b1; nxt = ST_FADDR; end
      ST_STORE: begin wr_req = 1'b1; nxt = ST_WRITE; end
      ST_WRITE: nxt = ST_FADDR;
      ST_HALT:  nxt = ST_HALT;
      default:  nxt = ST_FADDR;
    endcase
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MEM_AW = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load_en,
  input  logic [MEM_AW-1:0]       load_addr,
  input  logic [DATA_W-1:0]       load_data,
  output logic [DATA_W-OPC_W-1:0] bus_addr,
  output logic [DATA_W-1:0]       bus_wdata,
  output logic                    bus_rw_n,
  output logic [DATA_W-OPC_W-1:0] pc_o,
  output logic [DATA_W-1:0]       acc_o,
  output logic                    halted
);
  localparam int ADDR_W = DATA_W - OPC_W;
  localparam logic [ADDR_W-1:0] PC_STEP = 1;

  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] ir, mdr, tmp, acc, ram_q, alu_res;
  logic              rw_n;
  logic              ld_mar_pc, inc_pc, ld_ir, ld_mar_ir, pc_jump;
  logic              ld_tmp, ld_acc, wr_req;
  alu_op_e           alu_op;

  acc_cpu_ctrl u_ctrl (
    .clk(clk), .rst(rst), .opcode(ir[DATA_W-1 -: OPC_W]),
    .ld_mar_pc(ld_mar_pc), .inc_pc(inc_pc), .ld_ir(ld_ir),
    .ld_mar_ir(ld_mar_ir), .pc_jump(pc_jump), .ld_tmp(ld_tmp),
    .ld_acc(ld_acc), .wr_req(wr_req), .alu_op(alu_op), .halted(halted)
  );

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .op(alu_op), .acc(acc), .opnd(tmp), .res(alu_res)
  );

  acc_cpu_ram #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_ram (
    .clk(clk),
    .we(load_en | ~rw_n),
    .addr(load_en ? load_addr : mar[MEM_AW-1:0]),
    .wdata(load_en ? load_data : mdr),
    .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= '0;
      ir   <= '0;
      mar  <= '0;
      mdr  <= '0;
      tmp  <= '0;
      acc  <= '0;
      rw_n <= 1'b1;
    end else begin
      if (ld_mar_pc) mar <= pc;
      if (ld_mar_ir) mar <= ir[ADDR_W-1:0];
      if (inc_pc)    pc  <= pc + PC_STEP;
      if (pc_jump)   pc  <= ir[ADDR_W-1:0];
      if (ld_ir) begin
        ir  <= ram_q;
        mdr <= ram_q;
      end
      if (ld_tmp) begin
        tmp <= ram_q;
        mdr <= ram_q;
      end
      if (wr_req) mdr <= acc;
      if (ld_acc) acc <= alu_res;
      rw_n <= ~wr_req;
    end
  end

  assign bus_addr  = mar;
  assign bus_wdata = mdr;
  assign bus_rw_n  = rw_n;
  assign pc_o      = pc;
  assign acc_o     = acc;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rw_n,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] acc_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic              halted,
  input logic              pc_jump
);
  localparam logic [ADDR_W-1:0] ONE = 1;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (pc_o == '0 && acc_o == '0 && bus_rw_n && !halted)); // R1

  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !bus_rw_n |=> bus_rw_n); // R5

  AST_WRITE_DATA_IS_ACC: assert property (@(posedge clk) disable iff (rst)
    !bus_rw_n |-> bus_wdata == acc_o); // R5

  AST_STORE_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    (!bus_rw_n && !$past(rst)) |-> acc_o == $past(acc_o)); // R5

  AST_PC_STEP_OR_JUMP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && pc_o != $past(pc_o)) |->
      (pc_o == $past(pc_o) + ONE || $past(pc_jump))); // R7

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && pc_o == $past(pc_o))); // R8

  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    halted |-> bus_rw_n); // R8
endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_rw_n(bus_rw_n), .bus_wdata(bus_wdata),
  .acc_o(acc_o), .pc_o(pc_o), .halted(halted), .pc_jump(pc_jump)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;
  localparam int DATA_W = 16;
  localparam int MEM_AW = 8;
  localparam int ADDR_W = DATA_W - 4;
  localparam int NVEC   = 6;

  // {opcode, first operand, second operand, expected result}
  localparam logic [51:0] VEC [NVEC] = '{
    {4'h2, 16'h1234, 16'h0101, 16'h1335},
    {4'h2, 16'hFFFF, 16'h0002, 16'h0001},
    {4'h5, 16'h1234, 16'h0100, 16'h3400},
    {4'h5, 16'h00FF, 16'h00FF, 16'hFE01},
    {4'h5, 16'h0003, 16'h5556, 16'h0002},
    {4'h1, 16'h1111, 16'hA5A5, 16'hA5A5}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_en = 1'b0;
  logic [MEM_AW-1:0] load_addr = '0;
  logic [DATA_W-1:0] load_data = '0;
  logic [ADDR_W-1:0] bus_addr, pc_o;
  logic [DATA_W-1:0] bus_wdata, acc_o;
  logic bus_rw_n, halted;

  int n_chk = 0;
  int n_fail = 0;
  int wr_cnt = 0;
  int cyc = 0;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  bit done = 0;

  always #5 clk = ~clk;

  acc_cpu #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_dut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rw_n(bus_rw_n), .pc_o(pc_o), .acc_o(acc_o), .halted(halted)
  );

  always @(negedge clk) begin
    if (!rst && !bus_rw_n) begin
      wr_cnt  = wr_cnt + 1;
      wr_addr = bus_addr;
      wr_data = bus_wdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic [MEM_AW-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    load_en = 1'b1; load_addr = a; load_data = d;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset pc", 32'(pc_o), 32'h0);
    chk("R1 reset acc", 32'(acc_o), 32'h0);
    chk("R1 reset halted/strobe", {30'h0, halted, bus_rw_n}, 32'h1);
  endtask

  task automatic run();
    wr_cnt = 0;
    cyc = 0;
    @(negedge clk);
    rst = 1'b0;
    while (!halted && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
    if (!halted) chk("R8 watchdog halt", 32'h0, 32'h1);
  endtask

  task automatic halt_hold(input logic [ADDR_W-1:0] exp_pc, input int exp_wr);
    repeat (5) @(negedge clk);
    chk("R8 halted held", 32'(halted), 32'h1);
    chk("R8 pc frozen", 32'(pc_o), 32'(exp_pc));
    chk("R8 no write after halt", 32'(wr_cnt), 32'(exp_wr));
  endtask

  initial begin
    for (int v = 0; v < NVEC; v++) begin
      logic [3:0]  op;
      logic [15:0] a, b, e;
      string tag;
      {op, a, b, e} = VEC[v];
      tag = (op == 4'h2) ? "R3 add" : (op == 4'h5) ? "R4 mpy" : "R2 lda";
      enter_reset();
      // R11: program and data written through the load port under reset
      put(8'h00, 16'h1040);
      put(8'h01, {op, 12'h041});
      put(8'h02, 16'h3042);
      put(8'h03, 16'h1042);
      put(8'h04, 16'h0000);
      put(8'h40, a);
      put(8'h41, b);
      put(8'h42, 16'h0000);
      run();
      chk(tag, 32'(acc_o), 32'(e));
      chk("R5 one write strobe", 32'(wr_cnt), 32'h1);
      chk("R5 write addr", 32'(wr_addr), 32'h042);
      chk("R5 write data", 32'(wr_data), 32'(e));
      chk("R7 pc after halt", 32'(pc_o), 32'h5);
      chk("R10 cycles", 32'(cyc), 32'd31);
      halt_hold(12'h005, 1);
    end

    // R10 minimal program: load then halt
    enter_reset();
    put(8'h00, 16'h1020);
    put(8'h01, 16'h0000);
    put(8'h20, 16'h7777);
    run();
    chk("R10 load+halt cycles", 32'(cyc), 32'd11);
    chk("R2 load value", 32'(acc_o), 32'h7777);
    chk("R7 pc", 32'(pc_o), 32'h2);

    // R6 jump skips the following store
    enter_reset();
    put(8'h00, 16'h4010);
    put(8'h01, 16'h3030);
    put(8'h10, 16'h1020);
    put(8'h11, 16'h0000);
    put(8'h20, 16'hBEEF);
    run();
    chk("R6 jump target executed", 32'(acc_o), 32'hBEEF);
    chk("R6 skipped store", 32'(wr_cnt), 32'h0);
    chk("R6 pc", 32'(pc_o), 32'h012);
    chk("R10 jump cycles", 32'(cyc), 32'd15);
    halt_hold(12'h012, 0);

    // R9 undefined opcodes are no-ops
    enter_reset();
    put(8'h00, 16'h7123);
    put(8'h01, 16'hF000);
    put(8'h02, 16'h1020);
    put(8'h03, 16'h0000);
    put(8'h20, 16'h5A5A);
    run();
    chk("R9 nop then load", 32'(acc_o), 32'h5A5A);
    chk("R9 no write", 32'(wr_cnt), 32'h0);
    chk("R9 pc", 32'(pc_o), 32'h004);
    chk("R10 nop cycles", 32'(cyc), 32'd19);

    // R1 reset clears a nonzero accumulator
    enter_reset();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule